// File: doc/BRIEF.md
# Transposing Column-Burst Frame Buffer

This block stores a row-ordered 16-bit pixel stream from an image sensor into an external synchronous SRAM so that the frame is transposed on the way in, then reads the frame back column by column as linear bursts. The memory is organised as `LANES` banks. Every accepted pixel becomes exactly one single-bank write. The word address places the row index in its lowest bits, so walking a column is a run of consecutive addresses. A frame slot field above the column group field turns the memory into a ring of `SLOTS` frame buffers that absorbs a capture burst. One buffer instance serves one sensor hemisphere. The defaults are a small geometry; a full hemisphere uses 512 rows and 1024 columns.

The read side issues one address per cycle to all banks at once and receives one pixel from each bank. Each column is stored in a skewed bank. A lane rotator therefore reorders the bank words so that column `c` always leaves on lane `c mod LANES`. The output delivers `LANES` mutually synchronous column streams, which is `LANES` times the write rate.

A slot is read only after it has been completely written. When the writer would land on a slot still holding unread data, it discards that whole incoming frame and raises a sticky overflow flag.

The input stream never applies back-pressure: `in_ready` is constant high. The output is one valid/ready channel shared by all lanes. A beat moves on a rising edge where both `out_valid` and `out_ready` are high. While a beat is stalled, the block holds `out_valid` high and keeps `out_data` and `out_last` unchanged. The SRAM returns read data one cycle after `mem_re`. A two-entry output queue with credit-based issue keeps full rate under back-pressure without losing any in-flight word.

Top module: `fb_column_burst_buffer`

## Requirements
- R1: Each cycle with `in_valid` high is accepted (`in_ready` is always 1). A pixel of a stored frame produces exactly one write, with exactly one bit of `mem_we` set and `mem_wdata` equal to the pixel.
- R2: Pixels arrive row by row, with the column index incrementing first. Pixel (row r, column c) of the frame in slot s is written to bank `((c mod LANES) + (c div LANES)) mod LANES`. The write address is `s*(COLS/LANES)*ROWS + (c div LANES)*ROWS + r`, so the row sits in the least significant bits.
- R3: Reads of one column group use consecutive addresses for rows 0 to ROWS-1, and the same address is applied to all banks.
- R4: Output beats come in frame order, then column-group order, then row order. In the beat for group g and row r, lane l (bits `l*PIX_W +: PIX_W` of `out_data`) carries pixel (r, g*LANES+l).
- R5: No read of a slot is issued before every pixel of that slot's frame has been written. The slots are filled and read in ring order.
- R6: A frame whose first pixel arrives while the current write slot is still full is discarded: it makes no memory write and never appears at the output. The discard sets `overflow`, which stays high until reset.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data`/`out_last` hold their values.
- R8: `out_last` is 1 exactly on the beat carrying the last row (ROWS-1) of a column group.
- R9: During and after reset, `out_valid`, `overflow`, `mem_re` and every bit of `mem_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Always 1; the input is never stalled |
| in_data | input | PIX_W | Pixel value, row-ordered |
| mem_we | output | LANES | Per-bank write enable, at most one set |
| mem_waddr | output | ADDR_W | Write word address {slot, group, row} |
| mem_wdata | output | PIX_W | Write data |
| mem_re | output | 1 | Read strobe for all banks |
| mem_raddr | output | ADDR_W | Read word address shared by all banks |
| mem_rdata | input | LANES*PIX_W | Bank words, one cycle after `mem_re`, bank b at `b*PIX_W` |
| out_valid | output | 1 | Output beat present on all lanes |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | LANES*PIX_W | Lane l at `l*PIX_W` |
| out_last | output | 1 | Beat carries the last row of a column group |
| overflow | output | 1 | Sticky: a frame was discarded |

## Verification
Assertions check these properties on every cycle:
- at most one bank is written per cycle;
- no write targets a full slot and no read addresses a slot that is not full;
- completing a frame marks its slot full;
- read addresses step by one within a column;
- the overflow flag never falls;
- the output queue never overflows, and a stalled beat stays unchanged.

The actual transposition can only be shown by the bench's scenarios. The bench checks the skewed bank choice and address of each write, and the lane-to-column mapping of each beat against its own model. These scenarios also show that a discarded frame never emerges, and that frame order survives random gaps and random back-pressure.

// File: rtl/fb_pkg.sv
package fb_pkg;
  localparam int unsigned FB_PIX_W = 16;

  // Bank holding column col: skewed by the column group.
  function automatic int unsigned skew_bank(input int unsigned col, input int unsigned lanes);
    return ((col % lanes) + (col / lanes)) % lanes;
  endfunction
endpackage

// File: rtl/fb_wr_agu.sv
module fb_wr_agu #(
  parameter int unsigned PIX_W = fb_pkg::FB_PIX_W,
  parameter int unsigned LANES = 4,
  parameter int unsigned ROWS  = 16,
  parameter int unsigned COLS  = 16,
  parameter int unsigned SLOTS = 2,
  localparam int unsigned LANE_W = $clog2(LANES),
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned COL_W  = $clog2(COLS),
  localparam int unsigned GRP_W  = $clog2(COLS / LANES),
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned ADDR_W = SLOT_W + GRP_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_data,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              slot_full,
  output logic [LANES-1:0]  mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [PIX_W-1:0]  mem_wdata,
  output logic              frame_kept,
  output logic              frame_drop
);
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              dropping_q;
  logic              first_pix, last_pix, drop_now;
  logic [LANE_W-1:0] bank;
  logic [GRP_W-1:0]  grp;

  assign first_pix = (row_q == '0) && (col_q == '0);
  assign last_pix  = (row_q == ROW_W'(ROWS - 1)) && (col_q == COL_W'(COLS - 1));
  assign drop_now  = first_pix ? slot_full : dropping_q;
  assign bank      = LANE_W'(fb_pkg::skew_bank(int'(col_q), LANES));
  assign grp       = col_q[COL_W-1:LANE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q      <= '0;
      col_q      <= '0;
      dropping_q <= 1'b0;
    end else if (in_valid) begin
      if (first_pix) dropping_q <= slot_full;
      if (col_q == COL_W'(COLS - 1)) begin
        col_q <= '0;
        row_q <= (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  always_comb begin
    mem_we = '0;
    for (int b = 0; b < int'(LANES); b++) begin
      if (in_valid && !drop_now && (bank == LANE_W'(b))) mem_we[b] = 1'b1;
    end
  end

  assign mem_waddr  = {wr_slot, grp, row_q};
  assign mem_wdata  = in_data;
  assign frame_kept = in_valid && last_pix && !drop_now;
  assign frame_drop = in_valid && first_pix && slot_full;

  assert_onehot_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_we));
endmodule

// File: rtl/fb_rd_seq.sv
module fb_rd_seq #(
  parameter int unsigned LANES = 4,
  parameter int unsigned ROWS  = 16,
  parameter int unsigned COLS  = 16,
  parameter int unsigned SLOTS = 2,
  localparam int unsigned GRPS   = COLS / LANES,
  localparam int unsigned LANE_W = $clog2(LANES),
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned GRP_W  = $clog2(GRPS),
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned ADDR_W = SLOT_W + GRP_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic              slot_ready,
  input  logic              credit_ok,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic [LANE_W-1:0] issue_rot,
  output logic              issue_last,
  output logic              slot_done
);
  logic [ROW_W-1:0]  row_q;
  logic [GRP_W-1:0]  grp_q;
  logic [ADDR_W-1:0] prev_addr_q;

  assign mem_re     = slot_ready && credit_ok;
  assign mem_raddr  = {rd_slot, grp_q, row_q};
  assign issue_rot  = LANE_W'(int'(grp_q) % int'(LANES));
  assign issue_last = (row_q == ROW_W'(ROWS - 1));
  assign slot_done  = mem_re && issue_last && (grp_q == GRP_W'(GRPS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q       <= '0;
      grp_q       <= '0;
      prev_addr_q <= '0;
    end else if (mem_re) begin
      prev_addr_q <= mem_raddr;
      if (issue_last) begin
        row_q <= '0;
        grp_q <= (grp_q == GRP_W'(GRPS - 1)) ? '0 : grp_q + 1'b1;
      end else begin
        row_q <= row_q + 1'b1;
      end
    end
  end

  assert_linear_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && (mem_raddr[ROW_W-1:0] != '0)) |-> (mem_raddr == prev_addr_q + 1'b1));
endmodule

// File: rtl/fb_lane_xbar.sv
module fb_lane_xbar #(
  parameter int unsigned PIX_W = fb_pkg::FB_PIX_W,
  parameter int unsigned LANES = 4,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic [LANES*PIX_W-1:0] bank_data,
  input  logic [LANE_W-1:0]      rot,
  output logic [LANES*PIX_W-1:0] lane_data
);
  for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
    logic [LANE_W-1:0] src;
    assign src = LANE_W'(l) + rot;
    assign lane_data[l*PIX_W +: PIX_W] = bank_data[src*PIX_W +: PIX_W];
  end
endmodule

// File: rtl/fb_out_fifo.sv
module fb_out_fifo #(
  parameter int unsigned WIDTH = 65
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_ready,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  output logic [1:0]       count
);
  logic [WIDTH-1:0] ent_q [2];
  logic             wptr_q, rptr_q;
  logic [1:0]       cnt_q;
  logic             pop;

  assign out_valid = (cnt_q != 2'd0);
  assign out_data  = ent_q[rptr_q];
  assign pop       = out_valid && pop_ready;
  assign count     = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q   <= 1'b0;
      rptr_q   <= 1'b0;
      cnt_q    <= 2'd0;
      ent_q[0] <= '0;
      ent_q[1] <= '0;
    end else begin
      if (push) begin
        ent_q[wptr_q] <= push_data;
        wptr_q        <= ~wptr_q;
      end
      if (pop) rptr_q <= ~rptr_q;
      cnt_q <= cnt_q + {1'b0, push} - {1'b0, pop};
    end
  end

  assert_no_overfill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < 2'd2 || pop));
  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !pop_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/fb_column_burst_buffer.sv
module fb_column_burst_buffer #(
  parameter int unsigned PIX_W = fb_pkg::FB_PIX_W,
  parameter int unsigned LANES = 4,
  parameter int unsigned ROWS  = 16,
  parameter int unsigned COLS  = 16,
  parameter int unsigned SLOTS = 2,
  localparam int unsigned LANE_W = $clog2(LANES),
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned GRP_W  = $clog2(COLS / LANES),
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned ADDR_W = SLOT_W + GRP_W + ROW_W,
  localparam int unsigned BUS_W  = LANES * PIX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_data,
  output logic [LANES-1:0]  mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [PIX_W-1:0]  mem_wdata,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [BUS_W-1:0]  mem_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BUS_W-1:0]  out_data,
  output logic              out_last,
  output logic              overflow
);
  logic [SLOTS-1:0]  full_q;
  logic [SLOT_W-1:0] wr_slot_q, rd_slot_q;
  logic              ovf_q;
  logic              frame_kept, frame_drop, slot_done;
  logic              inflight_q, last_q;
  logic [LANE_W-1:0] rot_q, issue_rot;
  logic              issue_last, credit_ok, pop;
  logic [1:0]        fifo_cnt;
  logic [BUS_W-1:0]  lane_words;

  assign in_ready = 1'b1;
  assign overflow = ovf_q;
  assign pop      = out_valid && out_ready;
  assign credit_ok = (int'(fifo_cnt) + int'(inflight_q) - int'(pop)) < 2;

  fb_wr_agu #(.PIX_W(PIX_W), .LANES(LANES), .ROWS(ROWS), .COLS(COLS), .SLOTS(SLOTS)) u_wr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .wr_slot(wr_slot_q), .slot_full(full_q[wr_slot_q]),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .frame_kept(frame_kept), .frame_drop(frame_drop)
  );

  fb_rd_seq #(.LANES(LANES), .ROWS(ROWS), .COLS(COLS), .SLOTS(SLOTS)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_slot(rd_slot_q), .slot_ready(full_q[rd_slot_q]),
    .credit_ok(credit_ok), .mem_re(mem_re), .mem_raddr(mem_raddr),
    .issue_rot(issue_rot), .issue_last(issue_last), .slot_done(slot_done)
  );

  fb_lane_xbar #(.PIX_W(PIX_W), .LANES(LANES)) u_xbar (
    .bank_data(mem_rdata), .rot(rot_q), .lane_data(lane_words)
  );

  fb_out_fifo #(.WIDTH(BUS_W + 1)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(inflight_q), .push_data({last_q, lane_words}),
    .pop_ready(out_ready), .out_valid(out_valid), .out_data({out_last, out_data}),
    .count(fifo_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q     <= '0;
      wr_slot_q  <= '0;
      rd_slot_q  <= '0;
      ovf_q      <= 1'b0;
      inflight_q <= 1'b0;
      rot_q      <= '0;
      last_q     <= 1'b0;
    end else begin
      inflight_q <= mem_re;
      if (mem_re) begin
        rot_q  <= issue_rot;
        last_q <= issue_last;
      end
      if (frame_drop) ovf_q <= 1'b1;
      for (int s = 0; s < int'(SLOTS); s++) begin
        if (frame_kept && (wr_slot_q == SLOT_W'(s))) full_q[s] <= 1'b1;
        else if (slot_done && (rd_slot_q == SLOT_W'(s))) full_q[s] <= 1'b0;
      end
      if (frame_kept) wr_slot_q <= (wr_slot_q == SLOT_W'(SLOTS - 1)) ? '0 : wr_slot_q + 1'b1;
      if (slot_done)  rd_slot_q <= (rd_slot_q == SLOT_W'(SLOTS - 1)) ? '0 : rd_slot_q + 1'b1;
    end
  end

  assert_read_full_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> full_q[rd_slot_q]);
  assert_mark_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_kept |=> full_q[$past(wr_slot_q)]);
  assert_no_write_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we != '0) |-> !full_q[mem_waddr[ADDR_W-1 -: SLOT_W]]);
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
endmodule

// File: tb/test_fb_column_burst_buffer.sv
module test_fb_column_burst_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 16, LANES = 4, ROWS = 16, COLS = 16, SLOTS = 2;
  localparam int GRPS = COLS / LANES;
  localparam int BEATS = GRPS * ROWS;
  localparam int ADDR_W = $clog2(SLOTS) + $clog2(GRPS) + $clog2(ROWS);
  localparam int DEPTH = SLOTS * BEATS;
  localparam int BUS_W = LANES * PIX_W;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [PIX_W-1:0] in_data = '0;
  logic [LANES-1:0] mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [PIX_W-1:0] mem_wdata;
  logic mem_re;
  logic [BUS_W-1:0] mem_rdata = '0;
  logic out_valid, out_ready = 0, out_last, overflow;
  logic [BUS_W-1:0] out_data;

  fb_column_burst_buffer #(.PIX_W(PIX_W), .LANES(LANES), .ROWS(ROWS), .COLS(COLS), .SLOTS(SLOTS))
  i_fb_column_burst_buffer (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [PIX_W-1:0] bank_mem [LANES][DEPTH];
  always @(posedge clk) begin
    for (int b = 0; b < LANES; b++) begin
      if (mem_we[b]) bank_mem[b][mem_waddr] <= mem_wdata;
      if (mem_re) mem_rdata[b*PIX_W +: PIX_W] <= bank_mem[b][mem_raddr];
    end
  end

  int errors = 0, checks = 0;
  int ready_mode = 1;
  bit no_read_chk = 0;
  int cur_r, cur_c, cur_slot, wr_slot_m = 0;
  bit cur_keep;
  logic [BUS_W:0] exp_q [$];
  bit prev_stall = 0;
  logic [BUS_W:0] prev_beat;
  bit done = 0;

  function automatic logic [PIX_W-1:0] pix(int f, int r, int c);
    return {f[3:0], r[5:0], c[5:0]};
  endfunction

  task automatic check(bit ok, string req, logic [BUS_W:0] act, logic [BUS_W:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_frame(int f, bit keep, int gap_pct);
    if (keep) begin
      for (int g = 0; g < GRPS; g++)
        for (int r = 0; r < ROWS; r++) begin
          logic [BUS_W:0] b;
          b[BUS_W] = (r == ROWS - 1);
          for (int l = 0; l < LANES; l++) b[l*PIX_W +: PIX_W] = pix(f, r, g*LANES + l);
          exp_q.push_back(b);
        end
    end
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        while (($urandom % 100) < gap_pct) begin
          @(negedge clk); in_valid = 0;
        end
        @(negedge clk);
        cur_r = r; cur_c = c; cur_keep = keep; cur_slot = wr_slot_m;
        in_valid = 1; in_data = pix(f, r, c);
      end
    @(negedge clk); in_valid = 0;
    if (keep) wr_slot_m = (wr_slot_m + 1) % SLOTS;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // Monitor: drive ready at negedge, then sample a moment later.
  initial begin
    forever begin
      @(negedge clk);
      out_ready = (ready_mode == 1) ? 1'b1 : (ready_mode == 0) ? 1'b0 : (($urandom % 10) < 7);
      #1;
      if (rst_n) begin
        if (in_valid) begin
          logic [LANES-1:0] ewe;
          logic [ADDR_W-1:0] ea;
          ewe = cur_keep ? LANES'(1 << (((cur_c % LANES) + (cur_c / LANES)) % LANES)) : '0;
          ea = ADDR_W'(cur_slot * BEATS + (cur_c / LANES) * ROWS + cur_r);
          check(in_ready == 1'b1, "R1 in_ready", BUS_W'(in_ready), 1);
          if (cur_keep) begin
            check(mem_we == ewe && mem_wdata == in_data, "R1 write enable/data",
                  {mem_we, mem_wdata}, {ewe, in_data});
            check(mem_waddr == ea, "R2 write address", BUS_W'(mem_waddr), BUS_W'(ea));
          end else begin
            check(mem_we == '0, "R6 dropped frame write", BUS_W'(mem_we), 0);
          end
        end
        if (no_read_chk) check(mem_re == 1'b0, "R5 read before frame complete", BUS_W'(mem_re), 0);
        if (prev_stall)
          check(out_valid && {out_last, out_data} == prev_beat, "R7 stall hold",
                {out_last, out_data}, prev_beat);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) check(0, "R6 unexpected beat", {out_last, out_data}, 0);
          else begin
            logic [BUS_W:0] e;
            e = exp_q.pop_front();
            check({out_last, out_data} == e, "R4 R8 beat lanes/last", {out_last, out_data}, e);
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_beat = {out_last, out_data};
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    // R9 reset state
    check(out_valid == 0 && overflow == 0 && mem_re == 0 && mem_we == '0, "R9 reset outputs",
          {out_valid, overflow, mem_re, mem_we}, 0);
    rst_n = 1;
    // Directed: first frame into empty buffer, no reads until complete (R5)
    ready_mode = 1; no_read_chk = 1;
    send_frame(0, 1, 0);
    no_read_chk = 0;
    drain();
    check(overflow == 0, "R6 no overflow without pressure", BUS_W'(overflow), 0);
    // Directed overflow: stall output, fill ring, next frame discarded (R6)
    ready_mode = 0;
    send_frame(1, 1, 10);
    send_frame(2, 1, 0);
    send_frame(3, 0, 0);
    repeat (4) @(negedge clk);
    #2;
    check(overflow == 1, "R6 overflow set", BUS_W'(overflow), 1);
    check(out_valid == 1, "R5 stored frame offered", BUS_W'(out_valid), 1);
    ready_mode = 2;
    drain();
    #2;
    check(out_valid == 0, "R6 discarded frame absent", BUS_W'(out_valid), 0);
    // Random gaps and back-pressure, ring order (R3 R4 R5)
    for (int f = 4; f < 12; f++) begin
      while (exp_q.size() > BEATS) @(negedge clk);
      send_frame(f, 1, $urandom % 40);
    end
    drain();
    #2;
    check(overflow == 1, "R6 overflow sticky", BUS_W'(overflow), 1);
    check(out_valid == 0 && mem_re == 0, "R3 idle after drain", {out_valid, mem_re}, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule